// File: doc/BRIEF.md
# Memory sleep-mode entry controller

This block governs a low-power sleep state for a synchronous memory. A sleep request arrives on a pin that is asynchronous to the clock. The block first passes it through a synchronizer. The controller commits to sleep only when no chip enable or address strobe is asserted. It then spends a fixed window of clock cycles entering sleep before it raises the power-down enable. When the request is released, it spends the same window recovering before it lets traffic through again.

While the controller is entering, asleep or recovering, an access-gate output tells the surrounding memory logic to ignore chip enables and address strobes. Any access pending at the point of entry is therefore dropped, and no write can reach the array while it sleeps. Any access attempt seen during the entry or recovery window sets a sticky violation flag. Only reset clears that flag.

Top module: `mem_sleep_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, `pwr_down`, `access_gate` and `access_viol` are all 0.
- R2: `sleep_req` passes through two synchronizer flops. A request asserted before clock edge 1 causes no output change at edges 1 or 2, and the controller reacts at edge 3.
- R3: When a request is accepted, `access_gate` rises at once and stays high. `pwr_down` rises exactly two cycles later, at edge 5 counted from the request.
- R4: `pwr_down` is high only in the sleep state, and `access_gate` is high whenever `pwr_down` is high.
- R5: After `sleep_req` falls, `pwr_down` drops at edge 3, which starts a two-cycle recovery window with `access_gate` still high. `access_gate` falls at edge 5.
- R6: While `chip_en`, `addr_strobe_a` or `addr_strobe_b` is high, a synchronized request is held off and `access_gate` stays low. Entry starts on the first edge at which all three are low.
- R7: If the synchronized request drops during the entry window, the controller goes straight to recovery. `pwr_down` never rises. `access_gate` falls two cycles after recovery begins.
- R8: Any of `chip_en`, `addr_strobe_a` or `addr_strobe_b` high at a clock edge during the entry or recovery window sets `access_viol` from the next edge on. Once set, it stays high until reset.
- R9: Access inputs in the active state or in the sleep state leave `access_viol` at 0. In the sleep state they do not wake the block either: `pwr_down` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| chip_en | input | 1 | Chip enable seen by the memory, active high |
| addr_strobe_a | input | 1 | First address strobe, active high |
| addr_strobe_b | input | 1 | Second address strobe, active high |
| pwr_down | output | 1 | Power-down enable, high while asleep |
| access_gate | output | 1 | High when enables and strobes must be ignored |
| access_viol | output | 1 | Sticky flag for an access during entry or recovery |

## Verification
The assertions assume that `rst_n` is low at the first clock edge. They also assume that `sleep_req` changes at most once per synchronizer settling interval, so the synchronized request is a clean level. The bench drives every input, `sleep_req` included, on the falling clock edge. It holds the request level for several cycles at a time, so each transition reaches the state machine as one clean step. Access inputs are raised only inside deliberately chosen windows, and the bench samples outputs on the falling edge.

// File: rtl/mem_sleep_pkg.sv
// Package mem_sleep_pkg
// Shared state encoding for the sleep controller. It assumes nothing beyond
// being compiled before the modules that import it.
package mem_sleep_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_ENTER   = 2'd1,
        ST_SLEEP   = 2'd2,
        ST_RECOVER = 2'd3
    } slp_state_t;
endpackage

// File: rtl/mem_sleep_sync.sv
// Module mem_sleep_sync
// A chain of STAGES flops that brings an asynchronous level into the clk
// domain. It assumes the input holds each level for more than STAGES cycles.
module mem_sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the chain; reset clears every stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mem_sleep_fsm.sv
// Module mem_sleep_fsm
// The four-state sequencer: active, entering, asleep, recovering. Entry and
// recovery each last WIN cycles. It assumes req_s is already synchronized.
module mem_sleep_fsm
    import mem_sleep_pkg::*;
#(
    parameter int WIN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    input  logic       access_any,
    output slp_state_t state_o,
    output logic       pwr_down,
    output logic       access_gate
);
    localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    slp_state_t    state, nstate;
    logic [CW-1:0] cnt, ncnt;

    // Next-state and window-counter decode.
    always_comb begin
        nstate = state;
        ncnt   = cnt;
        case (state)
            ST_ACTIVE: begin
                if (req_s && !access_any) begin
                    nstate = ST_ENTER;
                    ncnt   = '0;
                end
            end
            ST_ENTER: begin
                if (!req_s) begin
                    nstate = ST_RECOVER;
                    ncnt   = '0;
                end else if (cnt == LAST) begin
                    nstate = ST_SLEEP;
                end else begin
                    ncnt = cnt + 1'b1;
                end
            end
            ST_SLEEP: begin
                if (!req_s) begin
                    nstate = ST_RECOVER;
                    ncnt   = '0;
                end
            end
            default: begin
                if (cnt == LAST) nstate = ST_ACTIVE;
                else             ncnt   = cnt + 1'b1;
            end
        endcase
    end

    // State and counter registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ACTIVE;
            cnt   <= '0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
        end
    end

    assign state_o     = state;
    assign pwr_down    = (state == ST_SLEEP);
    assign access_gate = (state != ST_ACTIVE);

    a_r1_reset_active: assert property (@(posedge clk)
        !rst_n |=> (state == ST_ACTIVE));
    a_r4_pd_gated: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> access_gate);
    a_r3_sleep_after_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENTER && req_s && cnt == LAST) |=> pwr_down);
    a_r6_hold_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && access_any) |=> !access_gate);
    a_r7_abort_to_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENTER && !req_s) |=> (state == ST_RECOVER));
    a_r5_release_from_recover: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(access_gate) |-> ($past(state) == ST_RECOVER));
endmodule

// File: rtl/mem_sleep_viol.sv
// Module mem_sleep_viol
// Sticky flag set by any access seen during the entry or recovery window.
// It assumes the in_window input is a registered state decode.
module mem_sleep_viol (
    input  logic clk,
    input  logic rst_n,
    input  logic in_window,
    input  logic access_any,
    output logic viol
);
    // Set on an access inside a window; only reset clears the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                       viol <= 1'b0;
        else if (in_window && access_any) viol <= 1'b1;
    end

    a_r8_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);
    a_r8_viol_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (in_window && access_any) |=> viol);
    a_r9_viol_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol) |-> $past(in_window));
endmodule

// File: rtl/mem_sleep_ctrl.sv
// Module mem_sleep_ctrl
// Top level. It synchronizes the sleep pin, sequences entry and recovery,
// and flags accesses that land inside a transition window. It assumes
// active-high enables and strobes.
module mem_sleep_ctrl
    import mem_sleep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WIN         = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic chip_en,
    input  logic addr_strobe_a,
    input  logic addr_strobe_b,
    output logic pwr_down,
    output logic access_gate,
    output logic access_viol
);
    logic       req_s;
    logic       access_any;
    logic       in_window;
    slp_state_t state;

    assign access_any = chip_en | addr_strobe_a | addr_strobe_b;
    assign in_window  = (state == ST_ENTER) || (state == ST_RECOVER);

    mem_sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sleep_req),
        .dout (req_s)
    );

    mem_sleep_fsm #(.WIN(WIN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_s      (req_s),
        .access_any (access_any),
        .state_o    (state),
        .pwr_down   (pwr_down),
        .access_gate(access_gate)
    );

    mem_sleep_viol u_viol (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_window (in_window),
        .access_any(access_any),
        .viol      (access_viol)
    );
endmodule

// File: tb/mem_sleep_ctrl_test.sv
// Directed bench for mem_sleep_ctrl. Inputs are driven on the falling edge
// and outputs are sampled there as well. "step(n)" waits n rising edges.
module mem_sleep_ctrl_test;
    logic clk = 1'b0;
    logic rst_n, sleep_req, chip_en, addr_strobe_a, addr_strobe_b;
    logic pwr_down, access_gate, access_viol;
    int   n_chk = 0;
    int   n_err = 0;

    always #4 clk = ~clk;

    mem_sleep_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .chip_en(chip_en),
        .addr_strobe_a(addr_strobe_a), .addr_strobe_b(addr_strobe_b),
        .pwr_down(pwr_down), .access_gate(access_gate), .access_viol(access_viol)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sleep_req = 1'b0; chip_en = 1'b0;
        addr_strobe_a = 1'b0; addr_strobe_b = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        chk("R1 pwr_down", pwr_down, 1'b0);
        chk("R1 access_gate", access_gate, 1'b0);
        chk("R1 access_viol", access_viol, 1'b0);
    endtask

    // R2, R3, R4, R5: full entry and exit
    task automatic t_cycle();
        do_reset();
        sleep_req = 1'b1;
        step(2);
        chk("R2 no reaction at edge 2", access_gate, 1'b0);
        step(1);
        chk("R2 gate at edge 3", access_gate, 1'b1);
        chk("R3 no pd at edge 3", pwr_down, 1'b0);
        step(1);
        chk("R3 no pd at edge 4", pwr_down, 1'b0);
        step(1);
        chk("R3 pd at edge 5", pwr_down, 1'b1);
        chk("R4 gate with pd", access_gate, 1'b1);
        step(3);
        chk("R4 pd held", pwr_down, 1'b1);
        sleep_req = 1'b0;
        step(2);
        chk("R5 pd at release edge 2", pwr_down, 1'b1);
        step(1);
        chk("R5 pd low at edge 3", pwr_down, 1'b0);
        chk("R5 gate in recovery", access_gate, 1'b1);
        step(1);
        chk("R5 gate at edge 4", access_gate, 1'b1);
        step(1);
        chk("R5 gate low at edge 5", access_gate, 1'b0);
        chk("R8 no viol on clean cycle", access_viol, 1'b0);
    endtask

    // R6: request held off while selected
    task automatic t_selected();
        do_reset();
        chip_en = 1'b1;
        sleep_req = 1'b1;
        step(6);
        chk("R6 held off while chip_en", access_gate, 1'b0);
        chip_en = 1'b0;
        addr_strobe_b = 1'b1;
        step(2);
        chk("R6 held off while strobe_b", access_gate, 1'b0);
        addr_strobe_b = 1'b0;
        step(1);
        chk("R6 entry when deselected", access_gate, 1'b1);
        chk("R9 no viol from active access", access_viol, 1'b0);
        step(2);
        chk("R6 sleep two cycles later", pwr_down, 1'b1);
    endtask

    // R7: request withdrawn during entry
    task automatic t_abort();
        do_reset();
        sleep_req = 1'b1;
        step(2);
        sleep_req = 1'b0;
        step(1);
        chk("R7 entry begun", access_gate, 1'b1);
        for (int i = 0; i < 4; i++) begin
            step(1);
            chk("R7 no pd during abort", pwr_down, 1'b0);
            if (i == 2) chk("R7 gate in recovery", access_gate, 1'b1);
        end
        chk("R7 gate released", access_gate, 1'b0);
    endtask

    // R8, R9: violation flag behaviour
    task automatic t_viol();
        do_reset();
        sleep_req = 1'b1;
        step(3);
        addr_strobe_a = 1'b1;
        step(1);
        addr_strobe_a = 1'b0;
        chk("R8 viol set in entry", access_viol, 1'b1);
        step(1);
        chk("R9 still sleeps", pwr_down, 1'b1);
        chip_en = 1'b1;
        step(3);
        chk("R9 sleep access keeps pd", pwr_down, 1'b1);
        chip_en = 1'b0;
        sleep_req = 1'b0;
        step(8);
        chk("R8 viol sticky", access_viol, 1'b1);
        do_reset();
        chk("R8 viol cleared by reset", access_viol, 1'b0);
        sleep_req = 1'b1;
        step(5);
        addr_strobe_b = 1'b1;
        step(2);
        addr_strobe_b = 1'b0;
        chk("R9 no viol from sleep access", access_viol, 1'b0);
        sleep_req = 1'b0;
        step(3);
        chip_en = 1'b1;
        step(1);
        chip_en = 1'b0;
        chk("R8 viol set in recovery", access_viol, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; sleep_req = 1'b0; chip_en = 1'b0;
        addr_strobe_a = 1'b0; addr_strobe_b = 1'b0;
        t_reset();
        t_cycle();
        t_selected();
        t_abort();
        t_viol();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule